// File: doc/BRIEF.md
# Ethernet Controller Initialization Sequencer

This block is a small bus master that brings one Ethernet MAC chip with 8-bit registers out of reset into a working state. A single start pulse launches a fixed series of accesses on a simple I/O port: address, write data, read data, a write flag, a request strobe and a ready handshake from the chip. The series selects twisted-pair line mode. It then asks the chip for permission to change its station address and keeps reading the same register until the chip reports that it is ready. Next it writes the 48-bit station address, which is taken from an input bus, one byte at a time into a single register. Last, it turns on both transmit and receive.

The chip's registers sit at even I/O addresses. The port address is twice the chip's native register index, and address bit 0 is always 0. Only the low byte of a read is examined. Writes put the register value on the low byte and drive the upper byte to zero. While the series runs, a busy flag is high. A one-cycle done pulse marks the end of the series. A system with a second chip uses a second instance.

Top module: `eth_init_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o` and `io_req_o` are low until a start is accepted.
- R2: A start pulse seen while `busy_o` is low is accepted. In the following cycle `busy_o` and `io_req_o` are high, and `io_req_o` stays equal to `busy_o` throughout.
- R3: The first access is a write (`io_we_o`=1) of 0x02 to address 0x1C, which selects twisted-pair line mode.
- R4: The second access is a write of 0x84 to address 0x24, which requests a station-address change.
- R5: Next come reads (`io_we_o`=0) of address 0x24. A read is repeated as long as bit 7 of the returned data is 1, and the sequence advances after the first read that returns bit 7 = 0. Bits 15:8 of the read data have no effect.
- R6: Next come six writes to address 0x2A. They carry `station_addr_i` bytes [7:0], [15:8], [23:16], [31:24], [39:32] and [47:40], in that order. The address is captured when the start is accepted.
- R7: The final access writes 0x03 to address 0x1A. In the cycle after it completes, `done_o` is high for exactly one cycle, with `busy_o` and `io_req_o` low.
- R8: An access completes on a clock edge where `io_req_o` and `io_ready_i` are both high. Until that edge, `io_req_o`, `io_addr_o`, `io_wdata_o` and `io_we_o` hold their values.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The access series is unchanged and no further accesses follow `done_o`.
- R10: `io_addr_o` bit 0 is 0 on every access. On writes, `io_wdata_o` bits 15:8 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted while not busy |
| station_addr_i | input | 48 | Station address to load, byte [7:0] sent first |
| io_addr_o | output | 8 | I/O port address (twice the register index) |
| io_wdata_o | output | 16 | Write data, register value in the low byte |
| io_we_o | output | 1 | 1 = write access, 0 = read access |
| io_req_o | output | 1 | Access request strobe |
| io_rdata_i | input | 16 | Read data from the chip, low byte used |
| io_ready_i | input | 1 | Chip completes the current access |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |

## Verification
The chip model inserts random wait states before asserting ready. A design that advanced on the strobe alone, or that changed the address or data while waiting, would log the wrong access list or trip the hold check. The model answers the readiness poll with a random number of not-ready replies, including none. A design that skipped the poll or stopped after one read would be caught, and so would one that tested the wrong bit, because the upper byte of every reply is filled with random values that include bit 15. The station address uses distinct byte patterns, which exposes a reversed byte order. A start pulse injected mid-sequence exposes a design that restarts or repeats the series.

// File: rtl/eis_pkg.sv
package eis_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  typedef enum logic [1:0] {OP_WR_CONST, OP_POLL, OP_WR_STATION} step_op_t;

  typedef struct packed {
    step_op_t   op;
    logic [6:0] reg_idx;
    logic [7:0] value;
  } step_desc_t;

  // native register indices (port address is twice these)
  localparam logic [6:0] IDX_LINE_MODE = 7'h0E;
  localparam logic [6:0] IDX_ADDR_CTRL = 7'h12;
  localparam logic [6:0] IDX_STATION   = 7'h15;
  localparam logic [6:0] IDX_MAC_CFG   = 7'h0D;

  localparam logic [7:0] VAL_TWISTED   = 8'h02;
  localparam logic [7:0] VAL_ADDR_REQ  = 8'h84;
  localparam logic [7:0] VAL_TXRX_ON   = 8'h03;

  localparam int POLL_BIT      = 7;
  localparam int STATION_BYTES = 6;
  localparam int FIRST_STATION = 3;
  localparam int NUM_STEPS     = FIRST_STATION + STATION_BYTES + 1;

endpackage

// File: rtl/eis_step_decode.sv
module eis_step_decode
  import eis_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int SEL_W  = 3
) (
  input  logic [STEP_W-1:0] step_i,
  output step_desc_t        desc_o,
  output logic [SEL_W-1:0]  byte_sel_o
);

  localparam logic [STEP_W-1:0] STEP_POLL  = STEP_W'(FIRST_STATION - 1);
  localparam logic [STEP_W-1:0] STEP_FIRST = STEP_W'(FIRST_STATION);
  localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(NUM_STEPS - 1);

  logic [STEP_W-1:0] rel_step;

  always_comb begin
    rel_step   = step_i - STEP_FIRST;
    byte_sel_o = rel_step[SEL_W-1:0];
    desc_o     = '{op: OP_WR_CONST, reg_idx: IDX_MAC_CFG, value: VAL_TXRX_ON};
    if (step_i == '0) begin
      desc_o = '{op: OP_WR_CONST, reg_idx: IDX_LINE_MODE, value: VAL_TWISTED};
    end else if (step_i < STEP_POLL) begin
      desc_o = '{op: OP_WR_CONST, reg_idx: IDX_ADDR_CTRL, value: VAL_ADDR_REQ};
    end else if (step_i == STEP_POLL) begin
      desc_o = '{op: OP_POLL, reg_idx: IDX_ADDR_CTRL, value: 8'h00};
    end else if (step_i < STEP_LAST) begin
      desc_o = '{op: OP_WR_STATION, reg_idx: IDX_STATION, value: 8'h00};
    end
  end

endmodule

// File: rtl/eis_byte_pick.sv
module eis_byte_pick #(
  parameter int NBYTES = 6,
  parameter int SEL_W  = 3
) (
  input  logic [8*NBYTES-1:0] word_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [7:0]          byte_o
);

  logic [7:0] lane [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane[g] = word_i[8*g +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < NBYTES; i++) begin
      if (sel_i == SEL_W'(i)) byte_o = lane[i];
    end
  end

endmodule

// File: rtl/eth_init_seq.sv
module eth_init_seq
  import eis_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [47:0]       station_addr_i,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [DATA_W-1:0] io_wdata_o,
  output logic              io_we_o,
  output logic              io_req_o,
  input  logic [DATA_W-1:0] io_rdata_i,
  input  logic              io_ready_i,
  output logic              busy_o,
  output logic              done_o
);

  localparam int STEP_W = $clog2(NUM_STEPS + 1);
  localparam int SEL_W  = $clog2(STATION_BYTES);
  localparam int MAC_W  = 8 * STATION_BYTES;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_STEPS - 1);

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              done_q, done_d;
  logic [MAC_W-1:0]  mac_q;
  logic              mac_load;

  step_desc_t        desc;
  logic [SEL_W-1:0]  byte_sel;
  logic [7:0]        mac_byte;
  logic              chip_busy;
  logic              unused_rdata;

  eis_step_decode #(.STEP_W(STEP_W), .SEL_W(SEL_W)) u_decode (
    .step_i    (step_q),
    .desc_o    (desc),
    .byte_sel_o(byte_sel)
  );

  eis_byte_pick #(.NBYTES(STATION_BYTES), .SEL_W(SEL_W)) u_pick (
    .word_i(mac_q),
    .sel_i (byte_sel),
    .byte_o(mac_byte)
  );

  assign chip_busy    = io_rdata_i[POLL_BIT];
  assign unused_rdata = ^{io_rdata_i[DATA_W-1:POLL_BIT+1], io_rdata_i[POLL_BIT-1:0]};

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    step_en  = 1'b0;
    done_d   = 1'b0;
    mac_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_RUN;
          step_d   = '0;
          step_en  = 1'b1;
          mac_load = 1'b1;
        end
      end
      ST_RUN: begin
        if (io_ready_i) begin
          if (desc.op == OP_POLL && chip_busy) begin
            step_en = 1'b0;
          end else if (step_q == STEP_LAST) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            step_d  = step_q + 1'b1;
            step_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_q <= '0;
    end else if (mac_load) begin
      mac_q <= station_addr_i;
    end
  end

  // outputs
  always_comb begin
    io_req_o   = (state_q == ST_RUN);
    io_we_o    = io_req_o && (desc.op != OP_POLL);
    io_addr_o  = io_req_o ? ADDR_W'({desc.reg_idx, 1'b0}) : '0;
    io_wdata_o = '0;
    if (io_we_o) begin
      io_wdata_o[7:0] = (desc.op == OP_WR_STATION) ? mac_byte : desc.value;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

endmodule

// File: rtl/eis_checker.sv
module eis_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] io_addr_o,
  input logic [DATA_W-1:0] io_wdata_o,
  input logic              io_we_o,
  input logic              io_req_o,
  input logic              io_ready_i,
  input logic              busy_o,
  input logic              done_o
);

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o && io_req_o);  // R2

  AST_REQ_MATCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_o == busy_o);  // R2

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_o && !io_ready_i) |=> io_req_o && $stable(io_addr_o)
      && $stable(io_wdata_o) && $stable(io_we_o));  // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !io_req_o);  // R7

  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_o |-> !io_addr_o[0]);  // R10

  AST_WDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_o && io_we_o) |-> (io_wdata_o[DATA_W-1:8] == '0));  // R10

endmodule

bind eth_init_seq eis_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eis_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .io_addr_o (io_addr_o),
  .io_wdata_o(io_wdata_o),
  .io_we_o   (io_we_o),
  .io_req_o  (io_req_o),
  .io_ready_i(io_ready_i),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/tb_eth_init_seq.sv
module tb_eth_init_seq;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [47:0] station_addr_i;
  logic [7:0]  io_addr_o;
  logic [15:0] io_wdata_o;
  logic        io_we_o;
  logic        io_req_o;
  logic [15:0] io_rdata_i;
  logic        io_ready_i;
  logic        busy_o;
  logic        done_o;

  eth_init_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .station_addr_i(station_addr_i),
    .io_addr_o(io_addr_o), .io_wdata_o(io_wdata_o), .io_we_o(io_we_o),
    .io_req_o(io_req_o), .io_rdata_i(io_rdata_i), .io_ready_i(io_ready_i),
    .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  bit finished = 0;

  // chip model state
  int          polls_left;
  int          max_wait;
  int          log_n;
  logic [7:0]  log_addr [64];
  logic [15:0] log_data [64];
  logic        log_we   [64];
  int          hold_errs;

  // expected series
  int          exp_n;
  logic [7:0]  exp_addr [64];
  logic [15:0] exp_data [64];
  logic        exp_we   [64];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] a, input logic [15:0] d, input logic w);
    exp_addr[exp_n] = a;
    exp_data[exp_n] = d;
    exp_we[exp_n]   = w;
    exp_n++;
  endtask

  function automatic string req_of(input int idx, input int polls);
    if (idx == 0) return "R3";
    if (idx == 1) return "R4";
    if (idx < 3 + polls) return "R5";
    if (idx < 9 + polls) return "R6";
    return "R7";
  endfunction

  task automatic build_exp(input int polls, input logic [47:0] mac);
    exp_n = 0;
    push_exp(8'h1C, 16'h0002, 1'b1);
    push_exp(8'h24, 16'h0084, 1'b1);
    for (int p = 0; p <= polls; p++) push_exp(8'h24, 16'h0000, 1'b0);
    for (int b = 0; b < 6; b++) push_exp(8'h2A, {8'h00, mac[8*b +: 8]}, 1'b1);
    push_exp(8'h1A, 16'h0003, 1'b1);
  endtask

  // chip model: random wait, then ready for one cycle; logs each access
  initial begin
    int          wait_cnt;
    logic        pend;
    logic [7:0]  pa;
    logic [15:0] pd;
    logic        pw;
    wait_cnt   = 0;
    pend       = 1'b0;
    pa = '0; pd = '0; pw = 1'b0;
    io_ready_i = 1'b0;
    io_rdata_i = 16'h0000;
    forever begin
      @(negedge clk);
      if (pend && io_req_o) begin
        if (io_addr_o != pa || io_wdata_o != pd || io_we_o != pw) hold_errs++;
      end
      pend = 1'b0;
      io_ready_i = 1'b0;
      if (io_req_o) begin
        if (wait_cnt > 0) begin
          wait_cnt--;
          pend = 1'b1;
          pa = io_addr_o; pd = io_wdata_o; pw = io_we_o;
          io_rdata_i = 16'($urandom);
        end else begin
          io_ready_i = 1'b1;
          io_rdata_i = 16'($urandom);
          if (!io_we_o && io_addr_o == 8'h24) begin
            io_rdata_i[7] = (polls_left > 0);
            if (polls_left > 0) polls_left--;
          end
          if (log_n < 64) begin
            log_addr[log_n] = io_addr_o;
            log_data[log_n] = io_we_o ? io_wdata_o : 16'h0000;
            log_we[log_n]   = io_we_o;
          end
          log_n++;
          wait_cnt = (max_wait > 0) ? int'($urandom % (max_wait + 1)) : 0;
        end
      end
    end
  end

  task automatic run_seq(input int polls, input logic [47:0] mac, input int wmax,
                         input bit glitch);
    int t;
    bit saw_done;
    build_exp(polls, mac);
    polls_left = polls;
    max_wait   = wmax;
    log_n      = 0;
    hold_errs  = 0;
    @(negedge clk);
    station_addr_i = mac;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    station_addr_i = ~mac;  // captured value must be used
    check(busy_o && io_req_o, "R2", "busy/req after start", {busy_o, io_req_o}, 2'b11);
    if (glitch) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;  // R9: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    saw_done = 0;
    while (!saw_done && t < 2000) begin
      if (done_o) saw_done = 1;
      else begin
        @(negedge clk);
        t++;
      end
    end
    check(saw_done, "R7", "done seen", saw_done, 1);
    check(!busy_o && !io_req_o, "R7", "busy/req low with done", {busy_o, io_req_o}, 2'b00);
    @(negedge clk);
    check(!done_o, "R7", "done one cycle", done_o, 0);
    check(log_n == exp_n, glitch ? "R9" : "R5", "access count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check(log_addr[i] == exp_addr[i] && log_we[i] == exp_we[i] &&
            log_data[i] == exp_data[i] && !log_addr[i][0],
            req_of(i, polls), $sformatf("access %0d addr/we/data", i),
            {log_addr[i], 7'h0, log_we[i], log_data[i]},
            {exp_addr[i], 7'h0, exp_we[i], exp_data[i]});
    end
    check(hold_errs == 0, "R8", "outputs held while waiting", hold_errs, 0);
    repeat (4) @(negedge clk);
    check(!io_req_o && !busy_o && log_n == exp_n, "R9", "no accesses after done",
          log_n, exp_n);
  endtask

  // watchdog
  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start_i = 1'b0;
    station_addr_i = '0;
    polls_left = 0;
    max_wait = 0;
    log_n = 0;
    hold_errs = 0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !io_req_o, "R1", "reset outputs",
          {busy_o, done_o, io_req_o}, 3'b000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy_o && !done_o && !io_req_o, "R1", "idle after reset",
          {busy_o, done_o, io_req_o}, 3'b000);

    // directed corner cases
    run_seq(0, 48'h0000_0000_0000, 0, 0);      // no not-ready polls, no waits
    run_seq(1, 48'hFFFF_FFFF_FFFF, 0, 0);
    run_seq(5, 48'h0605_0403_0201, 3, 0);      // R6 byte order
    run_seq(2, 48'hA1B2_C3D4_E5F6, 2, 1);      // R9 start while busy
    // random runs
    for (int k = 0; k < 8; k++) begin
      run_seq(int'($urandom % 8), {16'($urandom), 32'($urandom)},
              int'($urandom % 4), bit'($urandom % 2));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule